// File: doc/BRIEF.md
# Serial ADC Conversion and Readout Controller

This block drives a serial sampling converter whose single control strobe has two jobs. A rising edge on the strobe starts a conversion. A falling edge returns the converter to sampling and turns on its serial data output. When the system side asks for a conversion, the controller raises the strobe and holds it high for a programmable number of system clock cycles, which covers the conversion time. It then lowers the strobe and waits a setup interval. After that it produces a serial clock that idles low and captures one result word, most significant bit first, on the rising serial clock edges.

When the last bit is in, the controller presents the word as an unsigned straight-binary code on a parallel output, together with a one-cycle done pulse. The converter shifts out zeros if it receives extra serial clocks after the word. The controller therefore issues exactly one serial clock rising edge per result bit and then stops. The conversion time, the serial clock half-period and the word length are all parameters.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `conv_o`, `sclk_o`, `busy_o` and `done_o` are 0 and `result_o` is all zeros. A reset asserted partway through a transfer forces the same values.
- R2: When `start_i` is sampled high while idle, `conv_o` and `busy_o` go high on that clock edge. `conv_o` then stays high for exactly `CONV_CYC` system clock cycles.
- R3: `sclk_o` makes no rising edge while `conv_o` is high. The first rising edge comes exactly `HALF_DIV` cycles after `conv_o` falls.
- R4: `sclk_o` idles low, and each high or low phase lasts `HALF_DIV` cycles. Exactly `WORD_W` rising edges occur per transaction, and the clock is low again when the transaction ends.
- R5: `sdo_i` is sampled on each rising edge of `sclk_o`, and the first bit sampled is the MSB. `result_o` equals the converter's word exactly, as an unsigned code: all zeros stays 0 and all ones stays all ones.
- R6: `done_o` is high for exactly one cycle. That cycle is the state held after the clock edge `CONV_CYC + 2*WORD_W*HALF_DIV` edges after the edge that accepted `start_i`. `result_o` changes only as `done_o` rises and holds until the next transaction ends.
- R7: A `start_i` that arrives while `busy_o` is high is ignored, including during the done cycle. No new strobe rising edge follows it, and the conversion under way is not restarted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion and readout |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | WORD_W | Last captured conversion code |
| conv_o | output | 1 | Conversion strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdo_i | input | 1 | Serial data from the converter |

## Verification
Each result has a fixed cycle in which it is due, counted from the clock edge that accepts `start_i`:
- The strobe is high in the states after edges 0 through `CONV_CYC-1`.
- The first serial clock rise is seen `HALF_DIV` samples after the strobe falls.
- `done_o` is due in the state after edge `CONV_CYC + 2*WORD_W*HALF_DIV`, with `result_o` valid in that same sample.

The bench counts falling clock edges from the accepting edge and samples at each one, so every comparison falls at the exact cycle rather than within a window. A behavioural converter model drives data on serial clock falls and counts rising edges. It also flags any edge that arrives while the strobe is still high.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONV  = 3'd1,
    ST_SETUP = 3'd2,
    ST_SHIFT = 3'd3,
    ST_DONE  = 3'd4
  } adc_state_e;

  // width of a down counter able to hold max_val
  function automatic int adc_cnt_w(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  // edges from start acceptance to the edge entering the done state
  function automatic int adc_txn_cycles(input int conv_cyc, input int half_div, input int word_w);
    return conv_cyc + 2 * word_w * half_div;
  endfunction

endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] value_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= value_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);

  // a loaded nonzero value never expires on the following cycle
  p_no_early_expire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && value_i > 1) |=> !expire_o);
endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
  parameter int WORD_W = 12,
  localparam int BW    = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic              sdo_i,
  output logic [WORD_W-1:0] word_o,
  output logic [BW-1:0]     bits_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      bits_o <= '0;
    end else if (clr_i) begin
      word_o <= '0;
      bits_o <= '0;
    end else if (cap_i) begin
      word_o <= {word_o[WORD_W-2:0], sdo_i};  // MSB arrives first
      bits_o <= bits_o + 1'b1;
    end
  end

  p_no_extra_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |-> (bits_o < BW'(WORD_W)));
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int WORD_W   = 12,
  parameter int CONV_CYC = 40,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] result_o,
  output logic              conv_o,
  output logic              sclk_o,
  input  logic              sdo_i
);
  localparam int CW = adc_cnt_w((CONV_CYC > HALF_DIV) ? CONV_CYC : HALF_DIV);
  localparam int BW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] CONV_LD = CW'(CONV_CYC - 1);
  localparam logic [CW-1:0] HALF_LD = CW'(HALF_DIV - 1);

  adc_state_e state_q, state_d;
  logic sclk_q, sclk_d;
  logic tmr_load;
  logic [CW-1:0] tmr_val;
  logic tmr_expire;
  logic cap;
  logic clr;
  logic last_fall;
  logic [WORD_W-1:0] shift_word;
  logic [BW-1:0] bits;
  logic [WORD_W-1:0] result_q;

  // named internal events
  wire start_accept = (state_q == ST_IDLE) && start_i;

  adc_phase_timer #(.CW(CW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .value_i(tmr_val), .expire_o(tmr_expire)
  );

  adc_rx_shift #(.WORD_W(WORD_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .cap_i(cap), .sdo_i(sdo_i),
    .word_o(shift_word), .bits_o(bits)
  );

  always_comb begin
    state_d   = state_q;
    sclk_d    = sclk_q;
    tmr_load  = 1'b0;
    tmr_val   = HALF_LD;
    cap       = 1'b0;
    clr       = 1'b0;
    last_fall = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d  = ST_CONV;
        tmr_load = 1'b1;
        tmr_val  = CONV_LD;
        clr      = 1'b1;
      end
      ST_CONV: if (tmr_expire) begin
        state_d  = ST_SETUP;
        tmr_load = 1'b1;
      end
      ST_SETUP: if (tmr_expire) begin
        state_d  = ST_SHIFT;
        sclk_d   = 1'b1;
        cap      = 1'b1;
        tmr_load = 1'b1;
      end
      ST_SHIFT: if (tmr_expire) begin
        if (sclk_q) begin
          sclk_d = 1'b0;
          if (bits == BW'(WORD_W)) begin
            state_d   = ST_DONE;
            last_fall = 1'b1;
          end else begin
            tmr_load = 1'b1;
          end
        end else begin
          sclk_d   = 1'b1;
          cap      = 1'b1;
          tmr_load = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sclk_q   <= 1'b0;
      result_q <= '0;
    end else begin
      state_q <= state_d;
      sclk_q  <= sclk_d;
      if (last_fall) result_q <= shift_word;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_DONE);
  assign conv_o   = (state_q == ST_CONV);
  assign sclk_o   = sclk_q;
  assign result_o = result_q;

  // ---------------- assertions ----------------
  logic [31:0] chk_conv_hi;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chk_conv_hi <= '0;
    else if (conv_o) chk_conv_hi <= chk_conv_hi + 1;
    else             chk_conv_hi <= '0;
  end

  p_conv_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv_o) |-> (chk_conv_hi == 32'(CONV_CYC)));

  p_accept_raises_conv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> conv_o);

  p_no_sclk_in_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_o |-> !sclk_o);

  p_sclk_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_o) |-> $past(tmr_expire));

  p_sclk_low_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!sclk_o && bits == BW'(WORD_W)));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (done_o || $stable(result_o)));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> !$rose(conv_o));
endmodule

// File: tb/adc_rd_ctrl_tb_top.sv
module adc_rd_ctrl_tb_top;
  localparam int W    = 12;
  localparam int CONV = 40;
  localparam int HALF = 4;
  localparam int T    = CONV + HALF + (2 * W - 1) * HALF;  // edges to done state

  localparam logic [W-1:0] VEC [6] = '{12'h000, 12'hFFF, 12'h800, 12'h001, 12'hA5A, 12'h5A5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, done_o, conv_o, sclk_o;
  logic [W-1:0] result_o;
  logic sdo_i = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  adc_rd_ctrl #(.WORD_W(W), .CONV_CYC(CONV), .HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .result_o(result_o), .conv_o(conv_o), .sclk_o(sclk_o), .sdo_i(sdo_i)
  );

  // behavioural converter
  logic [W-1:0] model_word = '0;
  int m_idx = 0;
  int m_rises = 0;
  int m_early = 0;
  always @(posedge conv_o) m_rises = 0;
  always @(negedge conv_o) begin m_idx = 0; sdo_i = model_word[W-1]; end
  always @(negedge sclk_o) begin
    m_idx++;
    sdo_i = (m_idx < W) ? model_word[W-1-m_idx] : 1'b0;
  end
  always @(posedge sclk_o) begin
    if (conv_o) m_early++;
    m_rises++;
  end

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int r_conv_hi, r_gap, r_done_k, r_done_n;
  logic [W-1:0] r_res;

  task automatic run_txn(input logic [W-1:0] w, input int poke_k, input bit poke_done);
    int lowc = 0;
    bit seen = 1'b0;
    model_word = w;
    r_conv_hi = 0; r_gap = -1; r_done_k = -1; r_done_n = 0;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < T + 40; k++) begin
      if (conv_o) r_conv_hi++;
      if (!conv_o && r_conv_hi > 0 && !seen) begin
        if (sclk_o) begin r_gap = lowc; seen = 1'b1; end
        else lowc++;
      end
      if (done_o) begin
        r_done_n++;
        if (r_done_k < 0) begin r_done_k = k; r_res = result_o; end
      end
      start_i = (k == poke_k) || (poke_done && done_o);
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  task automatic check_txn(input logic [W-1:0] w);
    chk(r_conv_hi == CONV, "R2 strobe high cycles", r_conv_hi, CONV);
    chk(r_gap == HALF, "R3 strobe fall to first sclk rise", r_gap, HALF);
    chk(m_rises == W, "R4 sclk rising edges", m_rises, W);
    chk(r_res == w, "R5 result word", int'(r_res), int'(w));
    chk(r_done_k == T, "R6 done cycle", r_done_k, T);
    chk(r_done_n == 1, "R6 done pulse width", r_done_n, 1);
    chk(result_o == w, "R6 result held after done", int'(result_o), int'(w));
    chk(!busy_o && !sclk_o, "R4 idle after transaction", int'({busy_o, sclk_o}), 0);
  endtask

  initial begin
    #150000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!conv_o && !sclk_o, "R1 conv/sclk in reset", int'({conv_o, sclk_o}), 0);
    chk(!busy_o && !done_o, "R1 busy/done in reset", int'({busy_o, done_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(result_o == '0, "R1 result after reset", int'(result_o), 0);
    chk(!busy_o && !conv_o, "R1 idle after reset", int'({busy_o, conv_o}), 0);

    // vector table: R2..R6
    foreach (VEC[i]) begin
      run_txn(VEC[i], -1, 1'b0);
      check_txn(VEC[i]);
    end

    // R7: start mid-conversion and during the done cycle
    run_txn(12'h3C7, 10, 1'b1);
    check_txn(12'h3C7);
    chk(r_conv_hi == CONV, "R7 no restart from start while busy", r_conv_hi, CONV);

    // R7: start during the shift phase
    run_txn(12'hC38, CONV + 20, 1'b0);
    check_txn(12'hC38);

    // early edges (R3) over the whole run
    chk(m_early == 0, "R3 sclk rise while strobe high", m_early, 0);

    // R1: reset partway through the shift phase
    model_word = 12'hFFF;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (CONV + HALF + 3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!conv_o && !sclk_o && !busy_o && !done_o, "R1 mid-transfer reset outputs",
        int'({conv_o, sclk_o, busy_o, done_o}), 0);
    chk(result_o == '0, "R1 mid-transfer reset result", int'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_txn(12'h5A0, -1, 1'b0);
    check_txn(12'h5A0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule